// File: doc/BRIEF.md
# Peripheral Request Steering with Terminal-Count Release and Stop Capture

This block decides, channel by channel, where a peripheral's service request goes. Each channel owns one bit in a routing register. With the bit low the request is passed to the interrupt controller. With the bit high the same request becomes a start request for a small DMA engine and never reaches the interrupt controller. When the engine signals that a channel's byte count has reached zero, the hardware drops that channel's routing bit. Later requests from that peripheral then fall back to the interrupt path without any software action. The same event marks the channel's bit in a completion register.

One fixed channel, the serial-receive channel, may also be halted early by a stop request from its peripheral. The request is accepted only while that channel is routed to DMA. An accepted stop raises a halt strobe to the engine in the same cycle. It also records a sticky capture bit and releases the channel's routing bit. The stop bits of all other channels do not exist: they read as zero and cannot be written. Software reaches all registers through a byte-wide register port with a combinational read path.

Top module: `dma_req_steer`

## Requirements
- R1: After reset, every routing bit, every completion bit and the stop capture bit are 0, and every register address reads 0x00.
- R2: A channel whose routing bit is 0 drives its request on `intReq` and keeps `dmaStart` low for that channel.
- R3: A channel whose routing bit is 1 drives its request on `dmaStart` and keeps `intReq` low for that channel.
- R4: A `countZero` pulse on a channel clears that channel's routing bit at the next clock edge, so that later requests on that channel go to `intReq`.
- R5: If a register write to a routing byte falls in the same cycle as a `countZero` pulse for a channel in that byte, the channel's routing bit ends up 0 and the other bits take the written values.
- R6: A `stopReq` while the stop channel (channel 7) is routed to DMA raises `dmaHalt` in that same cycle, sets the capture bit (address 4, bit 7), and clears channel 7's routing bit. A `stopReq` while channel 7 is not routed to DMA has no effect.
- R7: In the stop register, bits 0 to 6 always read 0, and writing 1 to bit 7 never sets the capture bit.
- R8: Writing 0 to bit 7 of the stop register clears the capture bit. If an accepted stop falls in the same cycle as that write, the capture bit ends up 1.
- R9: A `countZero` pulse on a channel whose routing bit is 1 sets that channel's completion bit. A pulse on a channel whose routing bit is 0 does not set it. Writing 0 to a completion bit clears it. Writing 1 leaves it unchanged.
- R10: The register map is as follows. Address 0 holds routing bits for channels 0 to 7 and address 1 for channels 8 to 15, with bit n of each byte being channel 8*address+n. Addresses 2 and 3 hold the completion bits in the same layout. Address 4 holds the stop register. Addresses 5 to 7 read 0x00.
- R11: Routing uses the registered bit. A write to a routing bit changes the steering from the cycle after the write edge, and the cycle of the write itself still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| periphReq | input | 16 | Per-channel peripheral service requests |
| countZero | input | 16 | Per-channel byte-count-reached-zero strobes from the DMA engine |
| stopReq | input | 1 | Stop request from the serial-receive peripheral (channel 7) |
| intReq | output | 16 | Requests steered to the interrupt controller |
| dmaStart | output | 16 | Requests steered to the DMA engine as start requests |
| dmaHalt | output | 1 | Halt strobe for channel 7 when a stop is accepted |

## Verification
Two pairs of functions can land in the same clock cycle. The first is a software write to a routing byte together with the hardware release at terminal count. The second is a software clear of the stop capture bit together with the hardware setting it on an accepted stop. The bench provokes each one by holding the register write strobe and the hardware strobe in the same cycle. It then reads the register back after the edge. The hardware action must win the contested bit, and in the routing case the uncontested bits of the byte must still take the written value.

// File: rtl/dma_steer_pkg.sv
package dma_steer_pkg;

  typedef struct packed {
    logic stopSet;    // accepted stop: set capture bit
    logic stopWrSel;  // software write to the stop register
  } stopStrb_t;

endpackage

// File: rtl/dma_steer_ctrl.sv
module dma_steer_ctrl
  import dma_steer_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int STOP_CH = 7,
  parameter int ADDR_W  = 3
) (
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [NUM_CH-1:0]     enable,
  input  logic [NUM_CH-1:0]     periphReq,
  input  logic [NUM_CH-1:0]     countZero,
  input  logic                  stopReq,
  output logic [NUM_CH-1:0]     intReq,
  output logic [NUM_CH-1:0]     dmaStart,
  output logic                  dmaHalt,
  output logic [NUM_CH-1:0]     enClr,
  output logic [NUM_CH-1:0]     doneSet,
  output logic [NUM_CH/8-1:0]   enWrSel,
  output logic [NUM_CH/8-1:0]   stsWrSel,
  output stopStrb_t             strb
);

  localparam int BYTES = NUM_CH / 8;

  logic haltAccept;

  // steering from the registered routing bits
  assign intReq     = periphReq & ~enable;
  assign dmaStart   = periphReq & enable;
  assign haltAccept = stopReq & enable[STOP_CH];
  assign dmaHalt    = haltAccept;

  // hardware release: terminal count on any channel, accepted stop on the stop channel
  assign enClr   = countZero | (NUM_CH'(haltAccept) << STOP_CH);
  assign doneSet = countZero & enable;

  for (genvar b = 0; b < BYTES; b++) begin : gSel
    assign enWrSel[b]  = regWr && (regAddr == ADDR_W'(b));
    assign stsWrSel[b] = regWr && (regAddr == ADDR_W'(BYTES + b));
  end

  assign strb.stopSet   = haltAccept;
  assign strb.stopWrSel = regWr && (regAddr == ADDR_W'(2 * BYTES));

endmodule

// File: rtl/dma_steer_regs.sv
module dma_steer_regs
  import dma_steer_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int STOP_CH = 7,
  parameter int ADDR_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [7:0]            regWrData,
  output logic [7:0]            regRdData,
  input  logic [NUM_CH-1:0]     enClr,
  input  logic [NUM_CH-1:0]     doneSet,
  input  logic [NUM_CH/8-1:0]   enWrSel,
  input  logic [NUM_CH/8-1:0]   stsWrSel,
  input  stopStrb_t             strb,
  output logic [NUM_CH-1:0]     enable
);

  localparam int BYTES = NUM_CH / 8;
  localparam int STOP_BIT = STOP_CH % 8;

  logic [NUM_CH-1:0] sts, enNext, stsNext;
  logic              stopBit, stopNext;

  always_comb begin
    enNext  = enable;
    stsNext = sts;
    for (int b = 0; b < BYTES; b++) begin
      if (enWrSel[b])  enNext[b*8 +: 8]  = regWrData;
      if (stsWrSel[b]) stsNext[b*8 +: 8] = sts[b*8 +: 8] & regWrData;
    end
    enNext  = enNext & ~enClr;       // hardware release wins over software
    stsNext = stsNext | doneSet;     // hardware set wins over software clear
  end

  always_comb begin
    stopNext = stopBit;
    if (strb.stopWrSel && !regWrData[STOP_BIT]) stopNext = 1'b0;
    if (strb.stopSet) stopNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= '0;
      sts     <= '0;
      stopBit <= 1'b0;
    end else begin
      enable  <= enNext;
      sts     <= stsNext;
      stopBit <= stopNext;
    end
  end

  always_comb begin
    regRdData = 8'h00;
    for (int b = 0; b < BYTES; b++) begin
      if (regAddr == ADDR_W'(b))         regRdData = enable[b*8 +: 8];
      if (regAddr == ADDR_W'(BYTES + b)) regRdData = sts[b*8 +: 8];
    end
    if (regAddr == ADDR_W'(2 * BYTES)) regRdData[STOP_BIT] = stopBit;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    // R4: terminal count releases the routing bit
    a_r4_tc_release: assert property (@(posedge clk) disable iff (!rstN)
      enClr[i] |=> !enable[i]);
    // R9: completion recorded for a routed channel
    a_r9_done_set: assert property (@(posedge clk) disable iff (!rstN)
      doneSet[i] |=> sts[i]);
  end

  // R6: accepted stop sets capture and releases the stop channel
  a_r6_stop_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopSet |=> (stopBit && !enable[STOP_CH]));

  // R7: capture bit only rises from an accepted stop
  a_r7_hw_only_set: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopBit) |-> $past(strb.stopSet));

  // R8: capture bit only falls from a software write
  a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopBit) |-> $past(strb.stopWrSel));

endmodule

// File: rtl/dma_req_steer.sv
module dma_req_steer
  import dma_steer_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int STOP_CH = 7,
  parameter int ADDR_W  = $clog2(2 * (NUM_CH / 8) + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [NUM_CH-1:0]  periphReq,
  input  logic [NUM_CH-1:0]  countZero,
  input  logic               stopReq,
  output logic [NUM_CH-1:0]  intReq,
  output logic [NUM_CH-1:0]  dmaStart,
  output logic               dmaHalt
);

  localparam int BYTES = NUM_CH / 8;

  logic [NUM_CH-1:0] enable, enClr, doneSet;
  logic [BYTES-1:0]  enWrSel, stsWrSel;
  stopStrb_t         strb;

  dma_steer_ctrl #(.NUM_CH(NUM_CH), .STOP_CH(STOP_CH), .ADDR_W(ADDR_W)) uCtrl (
    .regWr(regWr), .regAddr(regAddr), .enable(enable),
    .periphReq(periphReq), .countZero(countZero), .stopReq(stopReq),
    .intReq(intReq), .dmaStart(dmaStart), .dmaHalt(dmaHalt),
    .enClr(enClr), .doneSet(doneSet), .enWrSel(enWrSel),
    .stsWrSel(stsWrSel), .strb(strb)
  );

  dma_steer_regs #(.NUM_CH(NUM_CH), .STOP_CH(STOP_CH), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .enClr(enClr), .doneSet(doneSet),
    .enWrSel(enWrSel), .stsWrSel(stsWrSel), .strb(strb), .enable(enable)
  );

  // R2, R3: a request never goes both ways
  a_r3_one_path: assert property (@(posedge clk) disable iff (!rstN)
    (intReq & dmaStart) == '0);

endmodule

// File: tb/tb_dma_req_steer.sv
`timescale 1ns/1ps
module tb_dma_req_steer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [15:0] periphReq = '0;
  logic [15:0] countZero = '0;
  logic        stopReq = 1'b0;
  logic [15:0] intReq, dmaStart;
  logic        dmaHalt;

  int checks = 0;
  int errors = 0;

  logic [15:0] expEn = '0;
  logic [15:0] expSts = '0;
  logic        expStop = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_steer dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .periphReq(periphReq),
    .countZero(countZero), .stopReq(stopReq), .intReq(intReq),
    .dmaStart(dmaStart), .dmaHalt(dmaHalt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input int a, input logic [7:0] d);
    regAddr = 3'(a); regWrData = d; regWr = 1'b1;
    cyc();
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string tag, input int a, input logic [7:0] exp);
    regAddr = 3'(a);
    #0.5;
    chk(tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic chkAll(input string tag);
    rdChk({tag, " en lo"}, 0, expEn[7:0]);
    rdChk({tag, " en hi"}, 1, expEn[15:8]);
    rdChk({tag, " sts lo"}, 2, expSts[7:0]);
    rdChk({tag, " sts hi"}, 3, expSts[15:8]);
    rdChk({tag, " stop"}, 4, {expStop, 7'b0});
  endtask

  task automatic chkSteer(input string tag, input logic [15:0] r);
    periphReq = r;
    #0.5;
    chk({tag, " int"}, 32'(intReq), 32'(r & ~expEn));
    chk({tag, " dma"}, 32'(dmaStart), 32'(r & expEn));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h3C96;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    chkAll("R1 reset");
    chkSteer("R1 R2 reset steer", 16'hFFFF);
    chk("R1 halt", 32'(dmaHalt), 0);

    // R2 R3 R10 routing patterns and readback
    foreach (pats[k]) begin
      wrReg(0, pats[k][7:0]); wrReg(1, pats[k][15:8]);
      expEn = pats[k];
      chkAll("R10 pattern");
      chkSteer("R2 R3 all", 16'hFFFF);
      chkSteer("R2 R3 mix", 16'h5A0F);
      chkSteer("R2 R3 xor", pats[k] ^ 16'h1234);
    end
    for (int i = 0; i < 16; i++) begin
      expEn = 16'(1) << i;
      wrReg(i / 8, expEn[(i/8)*8 +: 8]);
      wrReg(1 - i / 8, 8'h00);
      chkSteer("R3 onehot", 16'hFFFF);
      chkSteer("R2 R3 own", expEn);
    end

    // R4 R9 terminal count sweep
    wrReg(0, 8'hFF); wrReg(1, 8'hFF); expEn = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      countZero = 16'(1) << i;
      cyc();
      countZero = '0;
      expEn[i] = 1'b0; expSts[i] = 1'b1;
      rdChk("R4 release", i / 8, expEn[(i/8)*8 +: 8]);
      rdChk("R9 done", 2 + i / 8, expSts[(i/8)*8 +: 8]);
      chkSteer("R4 back to int", 16'(1) << i);
    end
    periphReq = '0;

    // R9 software clear semantics
    wrReg(2, 8'h0F); expSts[7:0] = 8'h0F;
    wrReg(3, 8'hFF);
    chkAll("R9 write");
    wrReg(2, 8'h00); wrReg(3, 8'h00); expSts = '0;
    countZero = 16'hFFFF; cyc(); countZero = '0;
    chkAll("R9 unrouted no set");

    // R5 write vs terminal count in the same cycle
    regAddr = 3'd0; regWrData = 8'hFF; regWr = 1'b1; countZero = 16'h0004;
    cyc();
    regWr = 1'b0; countZero = '0;
    expEn[7:0] = 8'hFB;
    chkAll("R5 race");

    // R11 write takes effect after the edge
    wrReg(0, 8'h00); expEn[7:0] = 8'h00;
    regAddr = 3'd0; regWrData = 8'h01; regWr = 1'b1; periphReq = 16'h0001;
    #0.5;
    chk("R11 old int", 32'(intReq), 32'h1);
    chk("R11 old dma", 32'(dmaStart), 32'h0);
    cyc();
    regWr = 1'b0; expEn[0] = 1'b1;
    chkSteer("R11 new", 16'h0001);
    periphReq = '0;

    // R6 stop ignored while not routed
    stopReq = 1'b1;
    #0.5;
    chk("R6 no halt", 32'(dmaHalt), 0);
    cyc();
    stopReq = 1'b0;
    chkAll("R6 ignored");

    // R6 stop accepted while routed
    wrReg(0, 8'h81); expEn[7:0] = 8'h81;
    stopReq = 1'b1;
    #0.5;
    chk("R6 halt", 32'(dmaHalt), 1);
    cyc();
    stopReq = 1'b0;
    expEn[7] = 1'b0; expStop = 1'b1;
    #0.5;
    chk("R6 halt drop", 32'(dmaHalt), 0);
    chkAll("R6 captured");
    chkSteer("R6 ch7 to int", 16'h0080);
    periphReq = '0;

    // R7 R8 software access to the stop register
    wrReg(4, 8'hFF);
    chkAll("R7 R8 write one keeps");
    wrReg(4, 8'h7F); expStop = 1'b0;
    chkAll("R8 clear");
    wrReg(4, 8'hFF);
    chkAll("R7 no sw set");

    // R8 accepted stop vs software clear in the same cycle
    wrReg(0, 8'h80); expEn[7:0] = 8'h80;
    regAddr = 3'd4; regWrData = 8'h00; regWr = 1'b1; stopReq = 1'b1;
    cyc();
    regWr = 1'b0; stopReq = 1'b0;
    expEn[7] = 1'b0; expStop = 1'b1;
    chkAll("R8 race");

    // R10 unmapped addresses
    for (int a = 5; a < 8; a++) rdChk("R10 unmapped", a, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule